// File: doc/BRIEF.md
# Bank and Operation Period Sequencer

This block is the control sequencer of a double-buffered matrix-multiply engine. It counts multiply operations and, for every operation, decides four things. It picks the weight bank that is read and the accumulator bank that is written. It picks whether the initialising operation code (operation 0) or the accumulating code (operation 1) applies. Independently of operations, it also picks the accumulator bank that the output transfer side reads. A per-row offset walks through the rows of the current weight bank.

All periods are 32-bit operation counts programmed on input ports. For a layer with K input groups of 64 channels, software typically programs these values:

| Period | Value |
|--------|-------|
| Weight switch | 64 |
| Operation 0 | 64 |
| Operation 1 | (K-1)·64 |
| Accumulator write switch | K·64 |
| Transfer switch | K·64 |

The outputs always describe the *next* operation or transfer. A strobe that is high on a rising edge consumes that decision and advances the counters. A restart command, or the synchronous reset, reloads everything from the programmed start values.

Top module: `bank_op_sequencer`

## Requirements
- R1: After reset or a restart command, the outputs take these values:
  - `wbank_sel` equals `wbank_start`.
  - `abank_sel` equals `abank_start`.
  - `xbank_sel` equals `abank_start XOR xfer_opposite`, so a 1 on `xfer_opposite` makes the transfer side start on the bank not being written.
  - `op_sel` is 0.
  - `row_off` is 0.
- R2: `wbank_sel` inverts after every `wsw_per` operation strobes counted since restart. When `wsw_per` is 0 it never inverts.
- R3: With `op1_per` nonzero, `op_sel` is 0 (initialising multiply) for the first `op0_per` operations of each cycle and 1 (multiply-plus) for the next `op1_per` operations, and then the cycle repeats.
- R4: When `op1_per` is 0, `op_sel` is 0 for every operation.
- R5: `abank_sel` inverts after every `asw_per` operation strobes. When `asw_per` is 0 it never inverts.
- R6: `xbank_sel` inverts after every `xsw_per` transfer strobes, counted independently of operation strobes. When `xsw_per` is 0 it never inverts.
- R7: `row_off` (6 bits for 64 rows) advances by one on each operation. It returns to 0 after the last operation of a weight period, and it wraps from 63 to 0.
- R8: In a cycle without an operation strobe, `wbank_sel`, `abank_sel`, `op_sel` and `row_off` keep their values. In a cycle without a transfer strobe, `xbank_sel` keeps its value.
- R9: A restart in the same cycle as either strobe wins: the strobes are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Reload counters and selects from start values |
| op_stb | input | 1 | One multiply operation consumed this cycle |
| xfer_stb | input | 1 | One output transfer consumed this cycle |
| wsw_per | input | 32 | Weight bank switch period (operations) |
| op0_per | input | 32 | Operation-0 period (operations) |
| op1_per | input | 32 | Operation-1 period (operations) |
| asw_per | input | 32 | Accumulator write switch period (operations) |
| xsw_per | input | 32 | Transfer read switch period (transfer strobes) |
| wbank_start | input | 1 | Start value of the weight bank select |
| abank_start | input | 1 | Start value of the accumulator write bank select |
| xfer_opposite | input | 1 | Transfer side starts on the opposite bank |
| wbank_sel | output | 1 | Weight bank read by the next operation |
| abank_sel | output | 1 | Accumulator bank written by the next operation |
| op_sel | output | 1 | 0 = initialising multiply, 1 = multiply-plus |
| xbank_sel | output | 1 | Accumulator bank read by the next transfer |
| row_off | output | 6 | Row offset for the next operation |

## Verification
The sequence is tried with the layer configurations for K = 1, 2 and 3 at 64-operation granularity. K = 1 separates a design that never enters operation 1 from one that does. K = 2 and K = 3 show whether the operation-1 span and the accumulator switch line up with the end of each phase cycle. Small random periods with random strobe gaps expose off-by-one errors at every boundary that the long periods hide. Directed runs cover several edge cases:
- a zero operation-1 period;
- a zero weight period, where the row offset must wrap at 64 by itself;
- long idle stretches;
- a restart that coincides with both strobes, which separates the restart priority from a late counter update.

// File: rtl/bops_pkg.sv
// Package: shared widths and the operation code type of the bank/operation
// sequencer. Assumes operation counts fit in PER_W bits.
package bops_pkg;
    localparam int PER_W_DEF = 32;   // width of every programmed period
    localparam int ROWS_DEF  = 64;   // rows per weight bank

    typedef enum logic {
        OP_INIT  = 1'b0,             // C = A x B
        OP_ACCUM = 1'b1              // C = C + A x B
    } op_code_e;
endpackage

// File: rtl/bops_toggle.sv
// Module: period toggle. Counts advance strobes and inverts its select after
// every PERIOD strobes; a zero period freezes the select. Assumes restart
// and reset load the select from start_val and clear the count.
module bops_toggle #(
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             start_val,
    input  logic             adv,
    input  logic [PER_W-1:0] period,
    output logic             sel,
    output logic             wrap
);
    logic [PER_W-1:0] cnt_q;
    logic             last;

    // Last strobe of the current period.
    always_comb begin
        last = (period != '0) && (cnt_q == period - 1'b1);
        wrap = adv && last;
    end

    // Count strobes and invert the select at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            sel   <= start_val;
        end else if (adv && (period != '0)) begin
            if (last) begin
                cnt_q <= '0;
                sel   <= ~sel;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bops_phase.sv
// Module: operation phase. Holds operation 0 for op0_per operations, then
// operation 1 for op1_per operations, and repeats. A zero op1_per keeps
// operation 0 forever. Assumes restart begins in operation 0.
module bops_phase
    import bops_pkg::*;
#(
    parameter int PER_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic [PER_W-1:0] op0_per,
    input  logic [PER_W-1:0] op1_per,
    output op_code_e         op_code
);
    logic [PER_W-1:0] cnt_q;
    logic [PER_W:0]   cnt_nx;
    logic             end_ph;

    // Decide whether this operation closes the current phase.
    always_comb begin
        cnt_nx = {1'b0, cnt_q} + 1'b1;
        if (op_code == OP_INIT)
            end_ph = (cnt_nx >= {1'b0, op0_per});
        else
            end_ph = (cnt_nx >= {1'b0, op1_per});
    end

    // Advance the phase counter and swap phases at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q   <= '0;
            op_code <= OP_INIT;
        end else if (adv) begin
            if (op_code == OP_INIT && op1_per == '0) begin
                cnt_q <= '0;
            end else if (end_ph) begin
                cnt_q   <= '0;
                op_code <= (op_code == OP_INIT) ? OP_ACCUM : OP_INIT;
            end else begin
                cnt_q <= cnt_nx[PER_W-1:0];
            end
        end
    end
endmodule

// File: rtl/bops_row.sv
// Module: row offset. Steps once per operation, wraps modulo ROWS and
// returns to zero when the weight period ends (clr together with adv).
module bops_row #(
    parameter int ROWS  = 64,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic             clr,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    // Step, wrap or clear the row offset.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            row <= '0;
        else if (adv) begin
            if (clr || row == ROW_LAST)
                row <= '0;
            else
                row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/bank_op_sequencer.sv
// Module: top of the bank and operation period sequencer. Outputs describe
// the next operation/transfer; a strobe high at a clock edge consumes it.
// Assumes periods are held stable between restarts.
module bank_op_sequencer
    import bops_pkg::*;
#(
    parameter int PER_W = PER_W_DEF,
    parameter int ROWS  = ROWS_DEF,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             op_stb,
    input  logic             xfer_stb,
    input  logic [PER_W-1:0] wsw_per,
    input  logic [PER_W-1:0] op0_per,
    input  logic [PER_W-1:0] op1_per,
    input  logic [PER_W-1:0] asw_per,
    input  logic [PER_W-1:0] xsw_per,
    input  logic             wbank_start,
    input  logic             abank_start,
    input  logic             xfer_opposite,
    output logic             wbank_sel,
    output logic             abank_sel,
    output logic             op_sel,
    output logic             xbank_sel,
    output logic [ROW_W-1:0] row_off
);
    logic     w_wrap, a_wrap_unused, x_wrap_unused;
    logic     x_start;
    op_code_e op_code;

    // Transfer side starts on the write bank, or its opposite.
    always_comb x_start = abank_start ^ xfer_opposite;

    bops_toggle #(.PER_W(PER_W)) u_wbank (
        .clk(clk), .rst_n(rst_n), .restart(restart), .start_val(wbank_start),
        .adv(op_stb), .period(wsw_per), .sel(wbank_sel), .wrap(w_wrap)
    );

    bops_toggle #(.PER_W(PER_W)) u_abank (
        .clk(clk), .rst_n(rst_n), .restart(restart), .start_val(abank_start),
        .adv(op_stb), .period(asw_per), .sel(abank_sel), .wrap(a_wrap_unused)
    );

    bops_toggle #(.PER_W(PER_W)) u_xbank (
        .clk(clk), .rst_n(rst_n), .restart(restart), .start_val(x_start),
        .adv(xfer_stb), .period(xsw_per), .sel(xbank_sel), .wrap(x_wrap_unused)
    );

    bops_phase #(.PER_W(PER_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .restart(restart), .adv(op_stb),
        .op0_per(op0_per), .op1_per(op1_per), .op_code(op_code)
    );

    bops_row #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .restart(restart), .adv(op_stb),
        .clr(w_wrap), .row(row_off)
    );

    // Present the operation code as a plain bit.
    always_comb op_sel = (op_code == OP_ACCUM);
endmodule

// File: rtl/bops_checker.sv
// Module: assertion checker bound to the sequencer top.
module bops_checker #(
    parameter int PER_W = 32,
    parameter int ROW_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             op_stb,
    input logic             xfer_stb,
    input logic [PER_W-1:0] op1_per,
    input logic             wbank_start,
    input logic             abank_start,
    input logic             xfer_opposite,
    input logic             wbank_sel,
    input logic             abank_sel,
    input logic             op_sel,
    input logic             xbank_sel,
    input logic [ROW_W-1:0] row_off
);
    a_r1_restart_state: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (wbank_sel == $past(wbank_start)) && (abank_sel == $past(abank_start))
                 && (xbank_sel == ($past(abank_start) ^ $past(xfer_opposite)))
                 && !op_sel && (row_off == '0));

    a_r8_op_side_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_stb && !restart) |=> $stable(wbank_sel) && $stable(abank_sel)
                               && $stable(op_sel) && $stable(row_off));

    a_r6_xbank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_stb && !restart) |=> $stable(xbank_sel));

    a_r4_op1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op1_per == '0 && !op_sel) |=> !op_sel);

    a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && !restart) |=> (row_off == '0) || (row_off == ROW_W'($past(row_off) + 1'b1)));
endmodule

bind bank_op_sequencer bops_checker #(.PER_W(PER_W), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .op_stb(op_stb), .xfer_stb(xfer_stb),
    .op1_per(op1_per), .wbank_start(wbank_start), .abank_start(abank_start),
    .xfer_opposite(xfer_opposite), .wbank_sel(wbank_sel), .abank_sel(abank_sel),
    .op_sel(op_sel), .xbank_sel(xbank_sel), .row_off(row_off)
);

// File: tb/sim_bank_op_sequencer.sv
module sim_bank_op_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, restart, op_stb, xfer_stb;
    logic [31:0] wsw_per, op0_per, op1_per, asw_per, xsw_per;
    logic        wbank_start, abank_start, xfer_opposite;
    logic        wbank_sel, abank_sel, op_sel, xbank_sel;
    logic [5:0]  row_off;

    int checks = 0, fails = 0;
    int unsigned n_ops = 0, n_xf = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_op_sequencer u0 (.*);

    function automatic bit exp_tog(bit start, int unsigned n, int unsigned per);
        if (per == 0) return start;
        return start ^ bit'((n / per) & 1);
    endfunction

    function automatic bit exp_op(int unsigned n);
        if (op1_per == 0) return 1'b0;
        return (n % (op0_per + op1_per)) >= op0_per;
    endfunction

    function automatic int unsigned exp_row(int unsigned n);
        int unsigned m = (wsw_per == 0) ? n : n % wsw_per;
        return m % 64;
    endfunction

    task automatic chk(int unsigned got, int unsigned expv, string req, string ctx);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s (%s) ops=%0d xf=%0d: actual %0d expected %0d", req, ctx, n_ops, n_xf, got, expv);
        end
    endtask

    task automatic check_all(string ctx);
        chk(wbank_sel, exp_tog(wbank_start, n_ops, wsw_per), "R2 weight bank", ctx);
        chk(op_sel, exp_op(n_ops), (op1_per == 0) ? "R4 op select" : "R3 op select", ctx);
        chk(abank_sel, exp_tog(abank_start, n_ops, asw_per), "R5 acc bank", ctx);
        chk(xbank_sel, exp_tog(abank_start ^ xfer_opposite, n_xf, xsw_per), "R6 xfer bank", ctx);
        chk(row_off, exp_row(n_ops), "R7 row offset", ctx);
    endtask

    task automatic step(bit op, bit xf, bit rs, string ctx);
        @(negedge clk);
        op_stb = op; xfer_stb = xf; restart = rs;
        @(posedge clk);
        #1;
        if (rs) begin n_ops = 0; n_xf = 0; end
        else begin
            if (op) n_ops++;
            if (xf) n_xf++;
        end
        check_all(ctx);
    endtask

    task automatic config_run(int unsigned w, int unsigned o0, int unsigned o1,
                              int unsigned a, int unsigned x);
        @(negedge clk);
        wsw_per = w; op0_per = o0; op1_per = o1; asw_per = a; xsw_per = x;
        wbank_start = 1'($urandom); abank_start = 1'($urandom); xfer_opposite = 1'($urandom);
        step(0, 0, 1, "R1 restart");
    endtask

    task automatic rand_run(int unsigned nsteps, string ctx);
        for (int i = 0; i < nsteps; i++)
            step(($urandom % 10) < 7, ($urandom % 10) < 4, 1'b0, ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; restart = 0; op_stb = 1; xfer_stb = 1;
        wsw_per = 3; op0_per = 2; op1_per = 3; asw_per = 5; xsw_per = 2;
        wbank_start = 1; abank_start = 0; xfer_opposite = 1;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1; op_stb = 0; xfer_stb = 0;

        // Small random periods stress every boundary.
        for (int c = 0; c < 6; c++) begin
            config_run(1 + $urandom % 9, 1 + $urandom % 5, $urandom % 6,
                       1 + $urandom % 9, 1 + $urandom % 7);
            rand_run(250, "random small periods");
        end

        // Layer configurations for K = 1, 2, 3.
        for (int k = 1; k <= 3; k++) begin
            config_run(64, 64, (k - 1) * 64, k * 64, k * 64);
            rand_run(k * 64 * 4, "layer K run");
        end

        // Zero op1 period: always initialising multiply.
        config_run(8, 5, 0, 6, 3);
        rand_run(120, "R4 op1 zero");

        // Zero weight period: bank frozen, row wraps at 64.
        config_run(0, 7, 9, 0, 0);
        for (int i = 0; i < 150; i++) step(1, 1, 0, "R7 zero weight period");

        // Idle stretch: nothing moves.
        for (int i = 0; i < 20; i++) step(0, 0, 0, "R8 idle");

        // Restart together with both strobes: strobes not counted.
        config_run(4, 3, 2, 5, 2);
        rand_run(37, "pre restart");
        step(1, 1, 1, "R9 restart with strobes");
        rand_run(60, "R9 after restart");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule